// File: doc/BRIEF.md
# Two-Bank Shared SRAM Priority Arbiter

This block sits between two masters, a processor port and a DMA port, and an on-chip SRAM built as two independent 32 KB banks. The most significant bit of each master's word address picks the upper or the lower bank. Each bank is arbitrated on its own, so the two masters can use different banks in the same cycle. When both masters want the same bank in the same cycle, a static per-bank priority bit decides which one wins. Round-robin fairness is not used.

The DMA port is gated by two enable bits that live in two separate configuration registers. The processor-side register holds the two priority bits and a share enable. A second register holds a side enable. DMA traffic is served only when both enables are set. A DMA request made while sharing is off is never acknowledged, and it raises a sticky error flag. A master that loses arbitration sees ready low and holds its request until it is granted. Reads return data one cycle after the grant. Writes are passed to the bank with their byte enables.

Top module: `dpsram_arbiter`

## Requirements
- R1: Word-address bit ADDR_W-1 selects the bank (1 = upper, 0 = lower). In the grant cycle the granted bank's enable is high and its word address equals the remaining ADDR_W-1 address bits.
- R2: Requests from both masters to different banks are both granted in the same cycle.
- R3: On an upper-bank conflict, priority bit 1 set gives the bank to the processor, and bit 1 clear gives it to the DMA port.
- R4: On a lower-bank conflict, priority bit 0 set gives the bank to the processor, and bit 0 clear gives it to the DMA port.
- R5: A master's ready is high in the same cycle its request is granted. It is low when the master has no request or loses. A bank is never granted to both masters.
- R6: A granted read's data appears on that master's read-data output in the cycle after its ready, and is the addressed word.
- R7: A granted write drives the bank's write enable, byte enables and write data unchanged, so only enabled bytes of the word change.
- R8: The DMA port is served only when both the share enable (loaded with the priority bits) and the side enable (loaded by its own strobe) are 1. Otherwise DMA ready stays low and the processor is served as if the DMA port were idle. A loaded value takes effect the cycle after its strobe.
- R9: A DMA request while DMA is not permitted sets the error flag at the next clock edge. The flag then stays set until reset.
- R10: After reset, both priority bits, both enables and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_wr | input | 1 | Load strobe for processor-side config register |
| pri_cpu_first | input | 2 | Priority bits, index 1 upper bank, index 0 lower bank; 1 = processor first |
| pri_share_en | input | 1 | Share enable loaded with pri_wr |
| side_wr | input | 1 | Load strobe for second config register |
| side_share_en | input | 1 | Side enable loaded with side_wr |
| cpu_req | input | 1 | Processor request |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_we | input | 1 | Processor write enable |
| cpu_be | input | DATA_W/8 | Processor byte enables |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdy | output | 1 | Processor granted this cycle |
| cpu_rdata | output | DATA_W | Processor read data, valid the cycle after a read grant |
| dma_req | input | 1 | DMA request |
| dma_addr | input | ADDR_W | DMA word address |
| dma_we | input | 1 | DMA write enable |
| dma_be | input | DATA_W/8 | DMA byte enables |
| dma_wdata | input | DATA_W | DMA write data |
| dma_rdy | output | 1 | DMA granted this cycle |
| dma_rdata | output | DATA_W | DMA read data, valid the cycle after a read grant |
| dma_err | output | 1 | Sticky flag: DMA requested while not permitted |
| bank_en | output | 2 | Bank enable, index 1 upper |
| bank_we | output | 2 | Bank write enable |
| bank_waddr | output | 2*(ADDR_W-1) | Bank word addresses, bank 0 in the low slice |
| bank_be | output | 2*DATA_W/8 | Bank byte enables |
| bank_wdata | output | 2*DATA_W | Bank write data |
| bank_rdata | input | 2*DATA_W | Bank read data, registered by the SRAM |

## Verification
Every setting of the two priority bits and the two enables is tried with all sixteen combinations of the two requests and their two bank selects. This separates split-bank concurrency from a conflict on the upper or the lower bank, and both of those from a blocked DMA port. Reads in that sweep return computed per-bank word patterns, which shows that data is routed from the right bank and word one cycle later. Masked writes from each master, one of them stalled by a conflict and then retried, are read back to confirm the byte merge. A second reset confirms that the error flag and the configuration clear.

// File: rtl/dpsram_arb_pkg.sv
// Shared definitions for the two-bank SRAM arbiter.
// Assumes exactly two banks (upper and lower) and two masters.
package dpsram_arb_pkg;
    localparam int NUM_BANKS = 2;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DMA = 1'b1
    } src_e;
endpackage

// File: rtl/dpsram_cfg_regs.sv
// Configuration and error state of the arbiter.
// Holds the processor-side register (priority bits, share enable), the
// second register (side enable) and the sticky DMA error flag.
// Assumes write strobes are single-cycle pulses; all state resets to 0.
module dpsram_cfg_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_wr,
    input  logic [1:0] pri_cpu_first,
    input  logic       pri_share_en,
    input  logic       side_wr,
    input  logic       side_share_en,
    input  logic       dma_req,
    output logic [1:0] cpu_first,
    output logic       dma_ok,
    output logic       dma_err
);
    logic share_q;
    logic side_q;

    // Processor-side register: priority bits and share enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_first <= 2'b00;
            share_q   <= 1'b0;
        end else if (pri_wr) begin
            cpu_first <= pri_cpu_first;
            share_q   <= pri_share_en;
        end
    end

    // Second register: side enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= 1'b0;
        end else if (side_wr) begin
            side_q <= side_share_en;
        end
    end

    // DMA is permitted only when both registers agree.
    always_comb begin
        dma_ok = share_q && side_q;
    end

    // Sticky error: set by a DMA request that cannot be served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_err <= 1'b0;
        end else if (dma_req && !dma_ok) begin
            dma_err <= 1'b1;
        end
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dma_err |=> dma_err);

    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ok) |=> dma_err);
endmodule

// File: rtl/dpsram_bank_arb.sv
// Arbiter and request multiplexer for one SRAM bank.
// Decides the owner of the bank for this cycle from the two qualified
// requests and the bank's static priority bit (1 = processor first),
// then drives the bank's control, address and write data from the owner.
// Assumes the DMA request is already gated by the share enables.
module dpsram_bank_arb
    import dpsram_arb_pkg::*;
#(
    parameter int BANK_ID = 0,
    parameter int WADDR_W = 13,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_bank,
    input  logic [WADDR_W-1:0]  cpu_waddr,
    input  logic                cpu_we,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                dma_req,
    input  logic                dma_bank,
    input  logic [WADDR_W-1:0]  dma_waddr,
    input  logic                dma_we,
    input  logic [DATA_W/8-1:0] dma_be,
    input  logic [DATA_W-1:0]   dma_wdata,
    input  logic                cpu_first,
    output logic                gnt_cpu,
    output logic                gnt_dma,
    output logic                bank_en,
    output logic                bank_we,
    output logic [WADDR_W-1:0]  bank_waddr,
    output logic [DATA_W/8-1:0] bank_be,
    output logic [DATA_W-1:0]   bank_wdata
);
    localparam logic MY_SEL = (BANK_ID != 0);

    logic cpu_hit;
    logic dma_hit;
    src_e owner;

    // Match each master's request against this bank.
    always_comb begin
        cpu_hit = cpu_req && (cpu_bank == MY_SEL);
        dma_hit = dma_req && (dma_bank == MY_SEL);
    end

    // Static priority resolution of a same-bank conflict.
    always_comb begin
        if (cpu_hit && dma_hit) begin
            owner = cpu_first ? SRC_CPU : SRC_DMA;
        end else if (dma_hit) begin
            owner = SRC_DMA;
        end else begin
            owner = SRC_CPU;
        end
        gnt_cpu = cpu_hit && (owner == SRC_CPU);
        gnt_dma = dma_hit && (owner == SRC_DMA);
    end

    // Steer the owner's access onto the bank.
    always_comb begin
        bank_en = gnt_cpu || gnt_dma;
        if (owner == SRC_DMA) begin
            bank_we    = gnt_dma && dma_we;
            bank_waddr = dma_waddr;
            bank_be    = dma_be;
            bank_wdata = dma_wdata;
        end else begin
            bank_we    = gnt_cpu && cpu_we;
            bank_waddr = cpu_waddr;
            bank_be    = cpu_be;
            bank_wdata = cpu_wdata;
        end
    end

    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_cpu && gnt_dma));

    a_r5_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_cpu |-> cpu_req) and (gnt_dma |-> dma_req));
endmodule

// File: rtl/dpsram_rd_return.sv
// Read-data return path for one master.
// Remembers which bank served the master's last granted read and routes
// that bank's registered output to the master one cycle later.
// Assumes the SRAM banks present read data the cycle after enable.
module dpsram_rd_return #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy,
    input  logic              we,
    input  logic              bank,
    input  logic [2*DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0] rdata
);
    logic bank_q;

    // Capture the bank of a granted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
        end else if (rdy && !we) begin
            bank_q <= bank;
        end
    end

    // Select the bank output that holds this master's data.
    always_comb begin
        rdata = bank_q ? bank_rdata[DATA_W +: DATA_W] : bank_rdata[0 +: DATA_W];
    end
endmodule

// File: rtl/dpsram_arbiter.sv
// Two-bank shared SRAM arbiter for a processor port and a DMA port.
// The top word-address bit picks the bank; each bank is arbitrated
// independently with a static priority bit. DMA is gated by two enables.
// Assumes masters hold request and address stable until ready.
module dpsram_arbiter
    import dpsram_arb_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pri_wr,
    input  logic [1:0]                    pri_cpu_first,
    input  logic                          pri_share_en,
    input  logic                          side_wr,
    input  logic                          side_share_en,
    input  logic                          cpu_req,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic                          cpu_we,
    input  logic [DATA_W/8-1:0]           cpu_be,
    input  logic [DATA_W-1:0]             cpu_wdata,
    output logic                          cpu_rdy,
    output logic [DATA_W-1:0]             cpu_rdata,
    input  logic                          dma_req,
    input  logic [ADDR_W-1:0]             dma_addr,
    input  logic                          dma_we,
    input  logic [DATA_W/8-1:0]           dma_be,
    input  logic [DATA_W-1:0]             dma_wdata,
    output logic                          dma_rdy,
    output logic [DATA_W-1:0]             dma_rdata,
    output logic                          dma_err,
    output logic [1:0]                    bank_en,
    output logic [1:0]                    bank_we,
    output logic [2*(ADDR_W-1)-1:0]       bank_waddr,
    output logic [2*(DATA_W/8)-1:0]       bank_be,
    output logic [2*DATA_W-1:0]           bank_wdata,
    input  logic [2*DATA_W-1:0]           bank_rdata
);
    localparam int WADDR_W = ADDR_W - 1;
    localparam int BE_W    = DATA_W / 8;
    localparam int MSB     = ADDR_W - 1;

    logic [1:0]           cpu_first;
    logic                 dma_ok;
    logic                 dma_req_ok;
    logic [NUM_BANKS-1:0] gnt_cpu_b;
    logic [NUM_BANKS-1:0] gnt_dma_b;

    dpsram_cfg_regs u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .pri_wr        (pri_wr),
        .pri_cpu_first (pri_cpu_first),
        .pri_share_en  (pri_share_en),
        .side_wr       (side_wr),
        .side_share_en (side_share_en),
        .dma_req       (dma_req),
        .cpu_first     (cpu_first),
        .dma_ok        (dma_ok),
        .dma_err       (dma_err)
    );

    // DMA requests only reach the banks when sharing is permitted.
    always_comb begin
        dma_req_ok = dma_req && dma_ok;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dpsram_bank_arb #(
            .BANK_ID (b),
            .WADDR_W (WADDR_W),
            .DATA_W  (DATA_W)
        ) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .cpu_req    (cpu_req),
            .cpu_bank   (cpu_addr[MSB]),
            .cpu_waddr  (cpu_addr[WADDR_W-1:0]),
            .cpu_we     (cpu_we),
            .cpu_be     (cpu_be),
            .cpu_wdata  (cpu_wdata),
            .dma_req    (dma_req_ok),
            .dma_bank   (dma_addr[MSB]),
            .dma_waddr  (dma_addr[WADDR_W-1:0]),
            .dma_we     (dma_we),
            .dma_be     (dma_be),
            .dma_wdata  (dma_wdata),
            .cpu_first  (cpu_first[b]),
            .gnt_cpu    (gnt_cpu_b[b]),
            .gnt_dma    (gnt_dma_b[b]),
            .bank_en    (bank_en[b]),
            .bank_we    (bank_we[b]),
            .bank_waddr (bank_waddr[b*WADDR_W +: WADDR_W]),
            .bank_be    (bank_be[b*BE_W +: BE_W]),
            .bank_wdata (bank_wdata[b*DATA_W +: DATA_W])
        );
    end

    // A master is ready when any bank grants it.
    always_comb begin
        cpu_rdy = |gnt_cpu_b;
        dma_rdy = |gnt_dma_b;
    end

    dpsram_rd_return #(.DATA_W(DATA_W)) u_ret_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy        (cpu_rdy),
        .we         (cpu_we),
        .bank       (cpu_addr[MSB]),
        .bank_rdata (bank_rdata),
        .rdata      (cpu_rdata)
    );

    dpsram_rd_return #(.DATA_W(DATA_W)) u_ret_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy        (dma_rdy),
        .we         (dma_we),
        .bank       (dma_addr[MSB]),
        .bank_rdata (bank_rdata),
        .rdata      (dma_rdata)
    );

    a_r2_split_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && dma_ok && (cpu_addr[MSB] != dma_addr[MSB]))
        |-> (cpu_rdy && dma_rdy));

    a_r3_upper_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && dma_ok && cpu_addr[MSB] && dma_addr[MSB] && cpu_first[1])
        |-> (cpu_rdy && !dma_rdy));

    a_r3_upper_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && dma_ok && cpu_addr[MSB] && dma_addr[MSB] && !cpu_first[1])
        |-> (dma_rdy && !cpu_rdy));

    a_r4_lower_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && dma_ok && !cpu_addr[MSB] && !dma_addr[MSB] && cpu_first[0])
        |-> (cpu_rdy && !dma_rdy));

    a_r4_lower_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && dma_ok && !cpu_addr[MSB] && !dma_addr[MSB] && !cpu_first[0])
        |-> (dma_rdy && !cpu_rdy));

    a_r8_dma_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_ok |-> !dma_rdy);

    a_r5_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req |-> !cpu_rdy) and (!dma_req |-> !dma_rdy));
endmodule

// File: tb/tb_dpsram_arbiter.sv
module tb_dpsram_arbiter;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 32;
    localparam int WA     = ADDR_W - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pri_wr, pri_share_en, side_wr, side_share_en;
    logic [1:0]  pri_cpu_first;
    logic        cpu_req, cpu_we, dma_req, dma_we;
    logic [13:0] cpu_addr, dma_addr;
    logic [3:0]  cpu_be, dma_be;
    logic [31:0] cpu_wdata, dma_wdata, cpu_rdata, dma_rdata;
    logic        cpu_rdy, dma_rdy, dma_err;
    logic [1:0]  bank_en, bank_we;
    logic [2*WA-1:0] bank_waddr;
    logic [7:0]  bank_be;
    logic [63:0] bank_wdata, bank_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem    [2][64];
    logic [31:0] sh_mem [2][64];
    logic [31:0] rdq    [2];
    logic [1:0]  sh_pri;
    logic        sh_dp, sh_bd, err_exp;

    always #2 clk = ~clk;

    dpsram_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .pri_wr(pri_wr), .pri_cpu_first(pri_cpu_first), .pri_share_en(pri_share_en),
        .side_wr(side_wr), .side_share_en(side_share_en),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_we(dma_we), .dma_be(dma_be),
        .dma_wdata(dma_wdata), .dma_rdy(dma_rdy), .dma_rdata(dma_rdata),
        .dma_err(dma_err),
        .bank_en(bank_en), .bank_we(bank_we), .bank_waddr(bank_waddr),
        .bank_be(bank_be), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    function automatic logic [31:0] init_word(input int b, input int i);
        return 32'h5A00_0000 + 32'(b << 16) + 32'(i);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = nw[8*k +: 8];
        return r;
    endfunction

    // SRAM bank model: registered read, byte-masked write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                rdq[b] <= 32'h0;
                for (int i = 0; i < 64; i++) mem[b][i] <= init_word(b, i);
            end
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (bank_en[b]) begin
                    if (bank_we[b]) begin
                        for (int k = 0; k < 4; k++)
                            if (bank_be[b*4 + k])
                                mem[b][bank_waddr[b*WA +: 6]][8*k +: 8] <= bank_wdata[b*32 + 8*k +: 8];
                    end else begin
                        rdq[b] <= mem[b][bank_waddr[b*WA +: 6]];
                    end
                end
            end
        end
    end
    assign bank_rdata = {rdq[1], rdq[0]};

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic shadow_reset();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 64; i++) sh_mem[b][i] = init_word(b, i);
        sh_pri = 2'b00; sh_dp = 1'b0; sh_bd = 1'b0; err_exp = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pri_wr = 0; side_wr = 0; pri_cpu_first = 0; pri_share_en = 0; side_share_en = 0;
        cpu_req = 0; cpu_addr = 0; cpu_we = 0; cpu_be = 0; cpu_wdata = 0;
        dma_req = 0; dma_addr = 0; dma_we = 0; dma_be = 0; dma_wdata = 0;
        shadow_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_cfg(input logic [1:0] pri, input logic dp, input logic bd);
        pri_wr = 1; pri_cpu_first = pri; pri_share_en = dp;
        side_wr = 1; side_share_en = bd;
        @(negedge clk);
        pri_wr = 0; side_wr = 0; pri_cpu_first = 0; pri_share_en = 0; side_share_en = 0;
        sh_pri = pri; sh_dp = dp; sh_bd = bd;
    endtask

    // One access cycle; called at a falling edge, returns at the next one.
    task automatic step(input logic creq, input logic [13:0] ca, input logic cwe,
                        input logic [3:0] cbe, input logic [31:0] cwd,
                        input logic dreq, input logic [13:0] da, input logic dwe,
                        input logic [3:0] dbe, input logic [31:0] dwd);
        logic ok_d, dh, same, ecr, edr, cr, dr;
        logic [31:0] ecd, edd;
        string tag;
        int cb, db;
        cpu_req = creq; cpu_addr = ca; cpu_we = cwe; cpu_be = cbe; cpu_wdata = cwd;
        dma_req = dreq; dma_addr = da; dma_we = dwe; dma_be = dbe; dma_wdata = dwd;
        #1;
        cb = int'(ca[13]); db = int'(da[13]);
        ok_d = sh_dp & sh_bd;
        dh = dreq & ok_d;
        same = (cb == db);
        ecr = creq & !(dh & same & !sh_pri[cb]);
        edr = dh & !(creq & same & sh_pri[db]);
        if (creq && dh && same) tag = (cb == 1) ? "R3" : "R4";
        else if (dreq && !ok_d) tag = "R8";
        else if (creq && dreq) tag = "R2";
        else tag = "R5";
        check(cpu_rdy === ecr, {tag, " cpu ready"}, 32'(cpu_rdy), 32'(ecr));
        check(dma_rdy === edr, {tag, " dma ready"}, 32'(dma_rdy), 32'(edr));
        if (ecr) begin
            check(bank_en[cb] === 1'b1 && bank_waddr[cb*WA +: WA] === ca[12:0],
                  "R1 cpu bank word address", 32'(bank_waddr[cb*WA +: WA]), 32'(ca[12:0]));
            if (cwe) check(bank_we[cb] === 1'b1 && bank_be[cb*4 +: 4] === cbe
                           && bank_wdata[cb*32 +: 32] === cwd,
                           "R7 cpu write fields", bank_wdata[cb*32 +: 32], cwd);
        end
        if (edr) begin
            check(bank_en[db] === 1'b1 && bank_waddr[db*WA +: WA] === da[12:0],
                  "R1 dma bank word address", 32'(bank_waddr[db*WA +: WA]), 32'(da[12:0]));
            if (dwe) check(bank_we[db] === 1'b1 && bank_be[db*4 +: 4] === dbe
                           && bank_wdata[db*32 +: 32] === dwd,
                           "R7 dma write fields", bank_wdata[db*32 +: 32], dwd);
        end
        cr = ecr & !cwe; dr = edr & !dwe;
        ecd = sh_mem[cb][ca[5:0]];
        edd = sh_mem[db][da[5:0]];
        if (ecr && cwe) sh_mem[cb][ca[5:0]] = merge(sh_mem[cb][ca[5:0]], cwd, cbe);
        if (edr && dwe) sh_mem[db][da[5:0]] = merge(sh_mem[db][da[5:0]], dwd, dbe);
        if (dreq && !ok_d) err_exp = 1'b1;
        @(negedge clk);
        cpu_req = 0; dma_req = 0; cpu_we = 0; dma_we = 0;
        if (cr) check(cpu_rdata === ecd, "R6 cpu read data", cpu_rdata, ecd);
        if (dr) check(dma_rdata === edd, "R6 dma read data", dma_rdata, edd);
        check(dma_err === err_exp, "R9 sticky error flag", 32'(dma_err), 32'(err_exp));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R10: reset state.
        check(dma_err === 1'b0, "R10 error flag after reset", 32'(dma_err), 32'h0);
        // R10: enables reset to 0, so DMA alone is blocked.
        step(0, 14'h0, 0, 4'h0, 0, 1, 14'h2005, 0, 4'h0, 0);

        // Sweep every configuration against every request/bank pattern.
        for (int cfg = 0; cfg < 16; cfg++) begin
            set_cfg(cfg[1:0], cfg[2], cfg[3]);
            for (int p = 0; p < 16; p++) begin
                logic [13:0] ca, da;
                ca = {p[2], 7'b0, 6'(p + cfg)};
                da = {p[3], 7'b0, 6'(3 * p + 1)};
                step(p[0], ca, 0, 4'h0, 0, p[1], da, 0, 4'h0, 0);
            end
        end

        // Writes: upper CPU-first, lower DMA-first, DMA permitted.
        set_cfg(2'b10, 1, 1);
        // R3 + R7: upper conflict, CPU masked write wins.
        step(1, 14'h2007, 1, 4'b0101, 32'h1122_3344, 1, 14'h2008, 1, 4'b1111, 32'hCAFE_F00D);
        // DMA retries alone.
        step(0, 14'h0, 0, 4'h0, 0, 1, 14'h2008, 1, 4'b1111, 32'hCAFE_F00D);
        // R4 + R7: lower conflict, DMA masked write wins over CPU read.
        step(1, 14'h0009, 0, 4'h0, 0, 1, 14'h0009, 1, 4'b1010, 32'hDEAD_BEEF);
        step(1, 14'h0009, 0, 4'h0, 0, 0, 14'h0, 0, 4'h0, 0);
        // R6: read back written words from both masters on split banks.
        step(1, 14'h2007, 0, 4'h0, 0, 1, 14'h0009, 0, 4'h0, 0);
        step(1, 14'h0009, 0, 4'h0, 0, 1, 14'h2008, 0, 4'h0, 0);

        // R10: second reset clears the sticky flag and configuration.
        do_reset();
        @(negedge clk);
        check(dma_err === 1'b0, "R10 error flag cleared by reset", 32'(dma_err), 32'h0);
        step(1, 14'h0001, 0, 4'h0, 0, 1, 14'h0002, 0, 4'h0, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule